// File: doc/BRIEF.md
# Eight-Lane Fixed-Point Vector Multiply-Accumulate Unit

This block is the multiply datapath of a vector coprocessor. It takes two source vectors of eight signed or unsigned 16-bit elements and an operation code. Each lane keeps a private 48-bit accumulator, seen as three 16-bit slices: high (bits 47:32), middle (bits 31:16) and low (bits 15:0). The unit either overwrites the accumulator with a product (multiply forms) or adds a product into it (accumulate forms). It also returns an eight-element 16-bit result vector that is taken from, or saturated out of, the new accumulator value. A readout operation copies one accumulator slice of every lane to the result.

A 4-bit element-select code reshuffles the second source vector before it reaches the lanes. It can pass the vector straight through, repeat one element of each pair or each half, or broadcast one element to every lane. A one-cycle `start` strobe issues an operation. The result vector and the updated accumulators are registered at that clock edge, and `done` pulses for one cycle. The result then holds until the next strobe.

Top module: `vmac_unit`

## Requirements
- R1: When `start` is high at a rising edge, `result` and `done` update at that edge. `done` is high only in the cycle after a strobe. `result` holds its value while no strobe arrives. Opcodes are 0 signed fractional multiply, 1 unsigned fractional multiply, 2 low multiply, 3 mid multiply, 4 mid-N multiply, 5 high multiply, 6 signed fractional accumulate, 7 unsigned fractional accumulate, 8 low accumulate, 9 mid accumulate, 10 mid-N accumulate, 11 high accumulate, 12 accumulator readout.
- R2: Lane i (element i sits at bits 16i+15:16i) uses second-operand element j, chosen by `elem_sel` as follows. Codes 0 and 1 give j=i. Code 2 gives j=i with bit 0 cleared. Code 3 gives j=i with bit 0 set. Codes 4 to 7 give j=(i&4)+(code-4). Codes 8 to 15 give j=code-8.
- R3: Opcode 0 treats both operands as signed and sets the accumulator to 2ab+0x8000, sign-extended to 48 bits. The result is the middle slice. When both operands are -32768, the accumulator becomes high 0, middle 0x8000, low 0x8000, and the result is 0x7FFF.
- R4: Opcode 1 sets the accumulator the same way as opcode 0. The result is 0 when that value is negative, 0xFFFF when it is 2^31 or more, and the middle slice otherwise.
- R5: Opcode 2 treats both operands as unsigned. It puts the upper 16 bits of the 32-bit product into the low slice, clears the middle and high slices, and returns the low slice.
- R6: Opcode 3 (first operand signed, second unsigned) and opcode 4 (first unsigned, second signed) put the 32-bit product into the middle and low slices, sign-extended into the high slice. Opcode 3 returns the middle slice. Opcode 4 returns the low 16 bits of the product.
- R7: Opcode 5 treats both operands as signed. It puts the 32-bit product into the high and middle slices, clears the low slice, and returns the product clamped to -32768..32767.
- R8: Opcodes 6 and 7 add 2ab (both signed), with its bit 0 at accumulator bit 0, to the 48-bit accumulator, wrapping modulo 2^48. Opcode 7 returns 0 when the new high slice is negative, 0xFFFF when bits 46:31 are not all zero, and the middle slice otherwise.
- R9: Opcode 8 adds the upper 16 bits of the unsigned 32-bit product into the accumulator at bit 0, carrying into the middle and high slices.
- R10: Opcode 9 (signed × unsigned) and opcode 10 (unsigned × signed) add the sign-extended product at bit 0. Opcode 11 (signed × signed) adds the sign-extended product at bit 16.
- R11: For opcodes 6, 9 and 11, the result is 0x8000 if the signed value of bits 47:16 is below -32768, 0x7FFF if it is above 32767, and the middle slice otherwise. For opcodes 8 and 10 the same two tests give 0x0000 and 0xFFFF, and the low slice otherwise.
- R12: Opcode 12 with `elem_sel` 8, 9 or 10 returns the high, middle or low slice of every lane. Any other code returns all zeros. The accumulators are left unchanged.
- R13: Opcodes 13 to 15 return all zeros and leave the accumulators unchanged.
- R14: After reset, `result` is zero, `done` is low and every accumulator is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue strobe, one cycle per operation |
| opcode | input | 4 | Operation code |
| elem_sel | input | 4 | Element-select code for the second operand, or slice code for readout |
| src_a | input | 128 | First source vector, eight 16-bit elements |
| src_b | input | 128 | Second source vector, eight 16-bit elements |
| result | output | 128 | Registered result vector |
| done | output | 1 | One-cycle pulse one clock after `start` |

## Verification
The bench aims at -32768 × -32768 in the fractional multiply. A design without the special case returns 0x8000 there, and a narrow product register corrupts the high slice read back afterwards. Repeated accumulation of extreme products drives every saturating form past both limits. A wrong sign-agreement test either wraps the result or clamps values that are still in range. Unsigned low products of 0xFFFF × 0xFFFF check that carries ripple from the low slice into the middle slice. Readouts of all three slices after each directed sequence, and after the spare opcodes and bad slice codes, expose an accumulator that a non-updating operation has touched. The select codes are driven with a ramp of distinct elements, so that a swapped pair or half index shows as a wrong element.

// File: rtl/vmac_pkg.sv
package vmac_pkg;

    localparam int LANES  = 8;
    localparam int ELEM_W = 16;
    localparam int CODE_W = 4;

    // operation codes; the numbering is the external encoding
    typedef enum logic [CODE_W-1:0] {
        OP_MUL_FRAC  = 4'd0,
        OP_MUL_UFRAC = 4'd1,
        OP_MUL_LO    = 4'd2,
        OP_MUL_MID   = 4'd3,
        OP_MUL_MIDN  = 4'd4,
        OP_MUL_HI    = 4'd5,
        OP_MAC_FRAC  = 4'd6,
        OP_MAC_UFRAC = 4'd7,
        OP_MAC_LO    = 4'd8,
        OP_MAC_MID   = 4'd9,
        OP_MAC_MIDN  = 4'd10,
        OP_MAC_HI    = 4'd11,
        OP_ACC_READ  = 4'd12
    } vmac_op_e;

    // slice codes used by the readout operation
    localparam logic [CODE_W-1:0] RD_HIGH = 4'd8;
    localparam logic [CODE_W-1:0] RD_MID  = 4'd9;
    localparam logic [CODE_W-1:0] RD_LOW  = 4'd10;

    // where a product lands inside the accumulator
    typedef enum logic [2:0] {
        PL_NONE,
        PL_FRAC,
        PL_LOW,
        PL_MID,
        PL_HIGH
    } place_e;

endpackage

// File: rtl/vmac_operand_sel.sv
module vmac_operand_sel
    import vmac_pkg::*;
#(
    parameter int LANES = vmac_pkg::LANES,
    parameter int EW    = vmac_pkg::ELEM_W
) (
    input  logic [LANES*EW-1:0] vec_i,
    input  logic [CODE_W-1:0]   sel_i,
    output logic [LANES*EW-1:0] vec_o
);

    localparam int IDX_W = $clog2(LANES);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [IDX_W-1:0] own_idx;
        logic [IDX_W-1:0] src_idx;

        assign own_idx = IDX_W'(g);

        always_comb begin
            src_idx = own_idx;
            if (sel_i[3]) begin
                src_idx = sel_i[IDX_W-1:0];                          // broadcast
            end else if (sel_i[2]) begin
                src_idx = {own_idx[IDX_W-1], sel_i[IDX_W-2:0]};      // per half
            end else if (sel_i[1]) begin
                src_idx = {own_idx[IDX_W-1:1], sel_i[0]};            // per pair
            end
        end

        assign vec_o[g*EW +: EW] = vec_i[int'(src_idx)*EW +: EW];
    end

endmodule

// File: rtl/vmac_lane.sv
module vmac_lane
    import vmac_pkg::*;
#(
    parameter int EW = vmac_pkg::ELEM_W
) (
    input  logic [EW-1:0]     a_i,
    input  logic [EW-1:0]     b_i,
    input  logic [3*EW-1:0]   acc_i,
    input  logic [CODE_W-1:0] op_i,
    input  logic [CODE_W-1:0] sel_i,
    output logic [3*EW-1:0]   acc_o,
    output logic [EW-1:0]     res_o
);

    localparam int AW = 3 * EW;          // accumulator width
    localparam int PW = 2 * EW + 2;      // product of two (EW+1)-bit signed values
    localparam logic [EW-1:0] S_MIN  = {1'b1, {(EW-1){1'b0}}};
    localparam logic [EW-1:0] S_MAX  = {1'b0, {(EW-1){1'b1}}};
    localparam logic [EW-1:0] U_MAX  = {EW{1'b1}};
    localparam logic [AW-1:0] ROUND  = AW'(1) << (EW - 1);

    logic              a_sgn, b_sgn, base_use, rnd_use;
    place_e            place;
    logic [EW:0]       a_x, b_x;
    logic signed [PW-1:0] prod;
    logic [AW-1:0]     prod_w;
    logic [AW-1:0]     addend;
    logic [AW-1:0]     sum;
    logic              hm_fits;
    logic              hm_neg;
    logic              prod_fits;
    logic [EW-1:0]     sat_signed, sat_unsigned;

    // operand signedness, product placement and base selection
    always_comb begin
        a_sgn    = 1'b1;
        b_sgn    = 1'b1;
        base_use = 1'b0;
        rnd_use  = 1'b0;
        place    = PL_MID;
        case (op_i)
            OP_MUL_FRAC, OP_MUL_UFRAC: begin
                place   = PL_FRAC;
                rnd_use = 1'b1;
            end
            OP_MUL_LO: begin
                a_sgn = 1'b0;
                b_sgn = 1'b0;
                place = PL_LOW;
            end
            OP_MUL_MID:  b_sgn = 1'b0;
            OP_MUL_MIDN: a_sgn = 1'b0;
            OP_MUL_HI:   place = PL_HIGH;
            OP_MAC_FRAC, OP_MAC_UFRAC: begin
                place    = PL_FRAC;
                base_use = 1'b1;
            end
            OP_MAC_LO: begin
                a_sgn    = 1'b0;
                b_sgn    = 1'b0;
                place    = PL_LOW;
                base_use = 1'b1;
            end
            OP_MAC_MID: begin
                b_sgn    = 1'b0;
                base_use = 1'b1;
            end
            OP_MAC_MIDN: begin
                a_sgn    = 1'b0;
                base_use = 1'b1;
            end
            OP_MAC_HI: begin
                place    = PL_HIGH;
                base_use = 1'b1;
            end
            default: begin
                place    = PL_NONE;
                base_use = 1'b1;
            end
        endcase
    end

    // one signed (EW+1)x(EW+1) multiplier covers every signedness mix
    assign a_x    = {a_sgn & a_i[EW-1], a_i};
    assign b_x    = {b_sgn & b_i[EW-1], b_i};
    assign prod   = $signed(a_x) * $signed(b_x);
    assign prod_w = {{(AW-PW){prod[PW-1]}}, prod};

    always_comb begin
        case (place)
            PL_FRAC: addend = {prod_w[AW-2:0], 1'b0};
            PL_LOW:  addend = {{(AW-EW){1'b0}}, prod[2*EW-1:EW]};
            PL_MID:  addend = prod_w;
            PL_HIGH: addend = {prod_w[AW-EW-1:0], {EW{1'b0}}};
            default: addend = '0;
        endcase
    end

    assign sum = (base_use ? acc_i : '0) + addend + (rnd_use ? ROUND : '0);

    // bits AW-1 .. 2EW-1 agree exactly when the high+middle pair fits EW signed bits
    assign hm_fits   = (&sum[AW-1:2*EW-1]) | ~(|sum[AW-1:2*EW-1]);
    assign hm_neg    = sum[AW-1];
    assign prod_fits = (&prod[PW-1:EW-1]) | ~(|prod[PW-1:EW-1]);

    assign sat_signed   = hm_fits ? sum[2*EW-1:EW] : (hm_neg ? S_MIN : S_MAX);
    assign sat_unsigned = hm_fits ? sum[EW-1:0]    : (hm_neg ? '0 : U_MAX);

    always_comb begin
        acc_o = sum;
        res_o = '0;
        case (op_i)
            OP_MUL_FRAC: begin
                if (a_i == S_MIN && b_i == S_MIN) res_o = S_MAX;
                else                              res_o = sum[2*EW-1:EW];
            end
            OP_MUL_UFRAC, OP_MAC_UFRAC: begin
                if (hm_neg)                      res_o = '0;
                else if (|sum[AW-2:2*EW-1])      res_o = U_MAX;
                else                             res_o = sum[2*EW-1:EW];
            end
            OP_MUL_LO:   res_o = sum[EW-1:0];
            OP_MUL_MID:  res_o = sum[2*EW-1:EW];
            OP_MUL_MIDN: res_o = sum[EW-1:0];
            OP_MUL_HI: begin
                if (prod_fits) res_o = prod[EW-1:0];
                else           res_o = prod[PW-1] ? S_MIN : S_MAX;
            end
            OP_MAC_FRAC, OP_MAC_MID, OP_MAC_HI: res_o = sat_signed;
            OP_MAC_LO, OP_MAC_MIDN:             res_o = sat_unsigned;
            OP_ACC_READ: begin
                acc_o = acc_i;
                case (sel_i)
                    RD_HIGH: res_o = acc_i[AW-1:2*EW];
                    RD_MID:  res_o = acc_i[2*EW-1:EW];
                    RD_LOW:  res_o = acc_i[EW-1:0];
                    default: res_o = '0;
                endcase
            end
            default: begin
                acc_o = acc_i;
                res_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/vmac_unit.sv
module vmac_unit
    import vmac_pkg::*;
#(
    parameter int LANES = vmac_pkg::LANES,
    parameter int EW    = vmac_pkg::ELEM_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CODE_W-1:0]   opcode,
    input  logic [CODE_W-1:0]   elem_sel,
    input  logic [LANES*EW-1:0] src_a,
    input  logic [LANES*EW-1:0] src_b,
    output logic [LANES*EW-1:0] result,
    output logic                done
);

    localparam int AW = 3 * EW;

    typedef struct packed {
        logic [LANES-1:0][AW-1:0] acc;
        logic [LANES*EW-1:0]      res;
        logic                     done;
    } state_t;

    state_t st_d, st_q;

    logic [LANES*EW-1:0]      b_shuf;
    logic [LANES-1:0][AW-1:0] lane_acc;
    logic [LANES-1:0][EW-1:0] lane_res;

    vmac_operand_sel #(
        .LANES (LANES),
        .EW    (EW)
    ) i_operand_sel (
        .vec_i (src_b),
        .sel_i (elem_sel),
        .vec_o (b_shuf)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        vmac_lane #(
            .EW (EW)
        ) i_lane (
            .a_i   (src_a[g*EW +: EW]),
            .b_i   (b_shuf[g*EW +: EW]),
            .acc_i (st_q.acc[g]),
            .op_i  (opcode),
            .sel_i (elem_sel),
            .acc_o (lane_acc[g]),
            .res_o (lane_res[g])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            for (int l = 0; l < LANES; l++) begin
                st_d.acc[l]          = lane_acc[l];
                st_d.res[l*EW +: EW] = lane_res[l];
            end
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result = st_q.res;
    assign done   = st_q.done;

endmodule

// File: rtl/vmac_unit_chk.sv
module vmac_unit_chk
    import vmac_pkg::*;
#(
    parameter int LANES = vmac_pkg::LANES,
    parameter int EW    = vmac_pkg::ELEM_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [CODE_W-1:0]   opcode,
    input logic [CODE_W-1:0]   elem_sel,
    input logic [EW-1:0]       a0,
    input logic [EW-1:0]       b0,
    input logic [LANES*EW-1:0] result,
    input logic                done
);

    localparam logic [EW-1:0] S_MIN = {1'b1, {(EW-1){1'b0}}};
    localparam logic [EW-1:0] S_MAX = {1'b0, {(EW-1){1'b1}}};

    AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);                                                         // R1
    AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start));                                                  // R1
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(result));                                             // R1
    AST_FRAC_MIN_CORNER: assert property (@(posedge clk) disable iff (!rst_n)
        (start && opcode == OP_MUL_FRAC && elem_sel == 4'd8 && a0 == S_MIN && b0 == S_MIN)
        |=> result[EW-1:0] == S_MAX);                                            // R3
    AST_UFRAC_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (start && opcode == OP_MUL_UFRAC && elem_sel == 4'd8 && (a0[EW-1] != b0[EW-1])
         && a0 != '0 && b0 != '0)
        |=> result[EW-1:0] == '0);                                               // R4
    AST_READ_BADSEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (start && opcode == OP_ACC_READ && (elem_sel < RD_HIGH || elem_sel > RD_LOW))
        |=> result == '0);                                                       // R12
    AST_SPARE_OP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (start && opcode > OP_ACC_READ) |=> result == '0);                       // R13

endmodule

bind vmac_unit vmac_unit_chk #(
    .LANES (LANES),
    .EW    (EW)
) i_vmac_unit_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .opcode   (opcode),
    .elem_sel (elem_sel),
    .a0       (src_a[EW-1:0]),
    .b0       (src_b[EW-1:0]),
    .result   (result),
    .done     (done)
);

// File: tb/test_vmac_unit.sv
module test_vmac_unit;

    localparam int NL = 8;
    localparam int W  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [3:0]      opcode = '0;
    logic [3:0]      elem_sel = '0;
    logic [NL*W-1:0] src_a = '0;
    logic [NL*W-1:0] src_b = '0;
    logic [NL*W-1:0] result;
    logic            done;

    longint model_acc [NL];
    int     n_chk = 0;
    int     n_bad = 0;
    bit     finished = 1'b0;

    always #4 clk = ~clk;

    vmac_unit i_vmac_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .opcode   (opcode),
        .elem_sel (elem_sel),
        .src_a    (src_a),
        .src_b    (src_b),
        .result   (result),
        .done     (done)
    );

    function automatic int pick(int code, int lane);
        if (code >= 8) return code - 8;
        if (code >= 4) return (lane / 4) * 4 + (code - 4);
        if (code >= 2) return (lane / 2) * 2 + (code - 2);
        return lane;
    endfunction

    function automatic longint sx48(longint v);
        return (v <<< 16) >>> 16;
    endfunction

    function automatic logic [15:0] sat_s(longint acc);
        longint hm = acc >>> 16;
        if (hm < -32768) return 16'h8000;
        if (hm > 32767)  return 16'h7fff;
        return 16'(hm);
    endfunction

    function automatic logic [15:0] sat_u(longint acc);
        longint hm = acc >>> 16;
        if (hm < -32768) return 16'h0000;
        if (hm > 32767)  return 16'hffff;
        return 16'(acc);
    endfunction

    function automatic string tag_of(int op);
        case (op)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3, 4: return "R6";
            5: return "R7";
            6, 7: return "R8,R11";
            8: return "R9,R11";
            9, 10, 11: return "R10,R11";
            12: return "R12";
            default: return "R13";
        endcase
    endfunction

    function automatic logic [15:0] rnd16();
        case ($urandom % 7)
            0: return 16'h8000;
            1: return 16'h7fff;
            2: return 16'hffff;
            3: return 16'h0000;
            4: return 16'h0001;
            default: return 16'($urandom);
        endcase
    endfunction

    // expected result; also advances the model accumulators
    function automatic logic [NL*W-1:0] model_step(int op, int sel, logic [NL*W-1:0] a, logic [NL*W-1:0] b);
        logic [NL*W-1:0] exp = '0;
        for (int l = 0; l < NL; l++) begin
            logic [15:0] ea = a[l*W +: W];
            logic [15:0] eb = b[pick(sel, l)*W +: W];
            longint sa = longint'($signed(ea));
            longint sb = longint'($signed(eb));
            longint ua = longint'(ea);
            longint ub = longint'(eb);
            longint acc = model_acc[l];
            longint r;
            logic [15:0] o = '0;
            case (op)
                0: begin
                    r = 2 * sa * sb + 32768;
                    acc = sx48(r);
                    o = (sa == -32768 && sb == -32768) ? 16'h7fff : 16'(r >>> 16);
                end
                1: begin
                    r = 2 * sa * sb + 32768;
                    acc = sx48(r);
                    o = (r < 0) ? 16'h0 : (r >= 64'd2147483648) ? 16'hffff : 16'(r >>> 16);
                end
                2: begin acc = (ua * ub) >>> 16; o = 16'(acc); end
                3: begin r = sa * ub; acc = r; o = 16'(r >>> 16); end
                4: begin r = ua * sb; acc = r; o = 16'(r); end
                5: begin
                    r = sa * sb;
                    acc = r <<< 16;
                    o = (r > 32767) ? 16'h7fff : (r < -32768) ? 16'h8000 : 16'(r);
                end
                6: begin acc = sx48(acc + 2 * sa * sb); o = sat_s(acc); end
                7: begin
                    acc = sx48(acc + 2 * sa * sb);
                    o = (acc < 0) ? 16'h0 : (acc >= 64'd2147483648) ? 16'hffff : 16'(acc >>> 16);
                end
                8:  begin acc = sx48(acc + ((ua * ub) >>> 16)); o = sat_u(acc); end
                9:  begin acc = sx48(acc + sa * ub); o = sat_s(acc); end
                10: begin acc = sx48(acc + ua * sb); o = sat_u(acc); end
                11: begin acc = sx48(acc + ((sa * sb) <<< 16)); o = sat_s(acc); end
                12: begin
                    if (sel == 8)       o = 16'(acc >>> 32);
                    else if (sel == 9)  o = 16'(acc >>> 16);
                    else if (sel == 10) o = 16'(acc);
                end
                default: o = '0;
            endcase
            model_acc[l] = acc;
            exp[l*W +: W] = o;
        end
        return exp;
    endfunction

    task automatic check(bit ok, string tag, logic [NL*W-1:0] act, logic [NL*W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    task automatic run_op(int op, int sel, logic [NL*W-1:0] a, logic [NL*W-1:0] b, string tag);
        logic [NL*W-1:0] exp = model_step(op, sel, a, b);
        string t = (tag == "") ? tag_of(op) : tag;
        @(negedge clk);
        opcode   = 4'(op);
        elem_sel = 4'(sel);
        src_a    = a;
        src_b    = b;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done === 1'b1, "R1 done", {127'b0, done}, 128'd1);
        check(result === exp, t, result, exp);
    endtask

    task automatic read_all(string tag);
        for (int s = 8; s <= 10; s++) run_op(12, s, '0, '0, tag);
    endtask

    function automatic logic [NL*W-1:0] splat(logic [15:0] v);
        return {NL{v}};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [NL*W-1:0] ramp;
        logic [NL*W-1:0] held;
        void'($urandom(32'h1f2e3d4c));
        for (int l = 0; l < NL; l++) model_acc[l] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R14: reset state at the ports, then accumulators through readout
        check(result === '0, "R14 result", result, '0);
        check(done === 1'b0, "R14 done", {127'b0, done}, '0);
        read_all("R14");

        // R2: unsigned 1 times signed b returns the selected element itself
        for (int l = 0; l < NL; l++) ramp[l*W +: W] = 16'(16'h1100 + l * 16'h0101);
        for (int s = 0; s < 16; s++) run_op(4, s, splat(16'h0001), ramp, "R2");

        // R1: no strobe -> done drops, result holds while inputs move
        held = result;
        @(negedge clk);
        src_a = '1;
        src_b = '1;
        @(negedge clk);
        check(done === 1'b0, "R1 pulse", {127'b0, done}, '0);
        check(result === held, "R1 hold", result, held);

        // R3 corner and accumulator content after it
        run_op(0, 8, splat(16'h8000), splat(16'h8000), "R3");
        read_all("R3");
        run_op(0, 0, splat(16'h4000), splat(16'hc000), "R3");
        // R4 negative and overflow paths
        run_op(1, 0, splat(16'h8000), splat(16'h7fff), "R4");
        run_op(1, 0, splat(16'h8000), splat(16'h8000), "R4");
        run_op(1, 0, splat(16'h6000), splat(16'h5000), "R4");
        // R5, R6, R7
        run_op(2, 0, splat(16'hffff), splat(16'hffff), "R5");
        read_all("R5");
        run_op(3, 0, splat(16'h8000), splat(16'hffff), "R6");
        run_op(4, 0, splat(16'hffff), splat(16'h8000), "R6");
        read_all("R6");
        run_op(5, 0, splat(16'h7fff), splat(16'h7fff), "R7");
        run_op(5, 0, splat(16'h8000), splat(16'h7fff), "R7");
        run_op(5, 0, splat(16'h0010), splat(16'hfff0), "R7");
        read_all("R7");
        // R8/R11: climb to positive saturation then down to negative saturation
        run_op(2, 0, '0, '0, "R5");
        for (int k = 0; k < 5; k++) run_op(6, 0, splat(16'h7fff), splat(16'h7fff), "R8,R11");
        for (int k = 0; k < 10; k++) run_op(6, 0, splat(16'h8000), splat(16'h7fff), "R8,R11");
        read_all("R8");
        for (int k = 0; k < 6; k++) run_op(7, 0, splat(16'h7fff), splat(16'h7fff), "R8");
        // R9: low-slice carries
        run_op(2, 0, '0, '0, "R5");
        for (int k = 0; k < 4; k++) run_op(8, 0, splat(16'hffff), splat(16'hffff), "R9");
        read_all("R9");
        // R10/R11
        for (int k = 0; k < 3; k++) run_op(11, 0, splat(16'h7fff), splat(16'h7fff), "R10,R11");
        run_op(9, 0, splat(16'h8000), splat(16'hffff), "R10,R11");
        run_op(10, 0, splat(16'hffff), splat(16'h8000), "R10,R11");
        read_all("R10");
        // R12 bad slice code, R13 spare opcodes: zeros and accumulators untouched
        run_op(12, 11, '1, '1, "R12");
        run_op(12, 3, '1, '1, "R12");
        read_all("R12");
        run_op(14, 0, splat(16'h7fff), splat(16'h7fff), "R13");
        run_op(13, 8, splat(16'h8000), splat(16'h8000), "R13");
        read_all("R13");

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [NL*W-1:0] ra, rb;
            int op = int'($urandom % 16);
            int sel = int'($urandom % 16);
            for (int l = 0; l < NL; l++) begin
                ra[l*W +: W] = rnd16();
                rb[l*W +: W] = rnd16();
            end
            run_op(op, sel, ra, rb, "");
            if (n % 25 == 0) read_all("R12");
        end

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule